// File: doc/BRIEF.md
# Host-Driven Packet FIFO Channel

This block is the processor-facing side of one packet link channel. No packet buffer memory sits behind it. A processor moves short packets one word at a time through a small register window, and the block carries them to and from a simple link stream. On the outgoing side, each beat carries a data word or an end marker. On the incoming side, each beat carries a data word and a flag that marks the final word of its packet.

The transmitter always keeps the newest words it has been given in reserve. These words stay in the transmit FIFO and are not offered to the link, so that an end marker can still follow the final word of a packet. A later data write releases the oldest reserved word. A write to the end-of-packet address releases every reserved word and queues an end marker behind them.

The processor checks the status flags before it touches either FIFO. It learns that a packet has arrived from a status bit or from a clear-on-read event register, which also drives an interrupt line.

Top module: `pkt_fifo_chan`

## Requirements
- R1: A processor write to address 0 (transmit data) while the transmit FIFO is not full stores the word. Words leave on the link in the order they were written, each with tx_mark = 0.
- R2: The link never sees the HOLD (default 2) most recently written data words of an open packet. A data write made while HOLD words are already reserved releases the oldest reserved word, so after n writes without an end, exactly max(0, n-HOLD) words are offered.
- R3: A write to address 1 (end of packet) while the transmit FIFO is not full releases all reserved words and queues one end-marker beat behind them (tx_mark = 1, tx_data = 0). With nothing reserved, it sends a lone end marker. A beat offered with tx_valid stays unchanged until tx_ready accepts it.
- R4: A write to address 0 or 1 while the transmit FIFO is full is dropped and leaves the queued contents intact. It sets a sticky overflow status bit that only reset clears.
- R5: Reading address 3 returns the status: bit 0 transmit FIFO empty (including reserved words), bit 1 transmit FIFO full, bit 2 receive FIFO not empty, bit 3 receive FIFO full, bit 4 head receive word ends a packet, bit 5 overflow. The empty bit drops on the first write into an empty transmit FIFO.
- R6: rx_ready is high whenever the receive FIFO has room. An accepted beat is stored together with its rx_last flag. A read of address 2 returns the head word and removes it. A read of address 2 on an empty FIFO returns 0 and changes nothing.
- R7: Event register bits: bit 0 is set when a beat with rx_last is accepted, bit 1 when an end marker leaves on the link, and bit 2 on a dropped transmit write. irq is high while any bit is set.
- R8: Reading address 4 returns the event register and then clears every bit. An event in the same cycle as that read is still recorded after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe (pops or clears at the edge) |
| cpu_addr | input | 3 | Register address 0..4 |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, combinational from current state |
| irq | output | 1 | Any event bit set |
| tx_valid | output | 1 | Outgoing beat available |
| tx_ready | input | 1 | Link accepts the outgoing beat |
| tx_data | output | DW | Outgoing data word |
| tx_mark | output | 1 | Outgoing beat is an end marker |
| rx_valid | input | 1 | Incoming beat present |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | DW | Incoming data word |
| rx_last | input | 1 | Incoming word ends its packet |

## Verification
Some properties are checked on every cycle. The reserve count never exceeds HOLD. An offered beat stays stable until it is accepted. An end-of-packet write leaves a beat on offer. Overflow stays sticky. Any store clears the matching empty flag. An event in the same cycle as a clear still lands in the event register. Other properties only the bench scenarios can show: the exact number of released words for each packet length, the order of words and marker on the link, the dropped writes at full, the tagging of the receive head, and the values returned by register reads.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam logic [2:0] ADDR_TXD  = 3'd0;
  localparam logic [2:0] ADDR_EOP  = 3'd1;
  localparam logic [2:0] ADDR_RXD  = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_INT  = 3'd4;
  localparam int STAT_W = 6;
  localparam int EVT_W  = 3;

  // Next count of reserved words after a data or end-of-packet write.
  function automatic int unsigned held_next(int unsigned held, bit wpush, bit epush,
                                            int unsigned lim);
    if (epush) return 0;
    if (wpush && held < lim) return held + 1;
    return held;
  endfunction

  // Next pointer value in a ring of the given depth.
  function automatic int unsigned ring_step(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/pfc_fifo.sv
module pfc_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  import pkt_fifo_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ring_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ring_step(int'(rd_ptr), DEPTH));
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/pfc_tx_hold.sv
module pfc_tx_hold #(
  parameter int HOLD = 2,
  parameter int CW   = 3,
  parameter int HW   = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wpush,
  input  logic          epush,
  input  logic [CW-1:0] count,
  output logic [HW-1:0] held,
  output logic          rel_ok
);
  import pkt_fifo_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= HW'(held_next(int'(held), wpush, epush, HOLD));
  end

  // Entries ahead of the reserved tail may go out on the link.
  assign rel_ok = int'(count) > int'(held);
endmodule

// File: rtl/pfc_int_status.sv
module pfc_int_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] bits
);
  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= (clr ? '0 : bits) | evt;
  end
endmodule

// File: rtl/pkt_fifo_chan.sv
module pkt_fifo_chan #(
  parameter int DW       = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int HOLD     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [2:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_mark,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last
);
  import pkt_fifo_pkg::*;
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int HW  = $clog2(HOLD + 1);

  // Decoded processor accesses
  logic wr_txd, wr_eop, rd_rxd, rd_int;
  assign wr_txd = cpu_wr && (cpu_addr == ADDR_TXD);
  assign wr_eop = cpu_wr && (cpu_addr == ADDR_EOP);
  assign rd_rxd = cpu_rd && (cpu_addr == ADDR_RXD);
  assign rd_int = cpu_rd && (cpu_addr == ADDR_INT);

  // Transmit path
  logic [TCW-1:0] tx_count;
  logic [HW-1:0]  held;
  logic [DW:0]    tx_din, tx_dout;
  logic tx_full, tx_empty, tx_word_push, tx_mark_push, tx_push, tx_pop;
  logic ovf_evt, tx_end_evt, status_ovf;

  assign tx_full      = (tx_count == TCW'(TX_DEPTH));
  assign tx_empty     = (tx_count == '0);
  assign ovf_evt      = (wr_txd || wr_eop) && tx_full;
  assign tx_word_push = wr_txd && !tx_full;
  assign tx_mark_push = wr_eop && !tx_full;
  assign tx_push      = tx_word_push || tx_mark_push;
  assign tx_din       = tx_mark_push ? {1'b1, {DW{1'b0}}} : {1'b0, cpu_wdata};
  assign tx_pop       = tx_valid && tx_ready;

  pfc_fifo #(.W(DW + 1), .DEPTH(TX_DEPTH), .CW(TCW)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .din(tx_din), .dout(tx_dout), .count(tx_count));

  pfc_tx_hold #(.HOLD(HOLD), .CW(TCW), .HW(HW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wpush(tx_word_push), .epush(tx_mark_push),
    .count(tx_count), .held(held), .rel_ok(tx_valid));

  assign tx_data    = tx_dout[DW-1:0];
  assign tx_mark    = tx_dout[DW];
  assign tx_end_evt = tx_pop && tx_mark;

  always_ff @(posedge clk) begin
    if (!rst_n)       status_ovf <= 1'b0;
    else if (ovf_evt) status_ovf <= 1'b1;
  end

  // Receive path
  logic [RCW-1:0] rx_count;
  logic [DW:0]    rx_dout;
  logic rx_full, rx_empty, rx_push, rx_pop, rx_end_evt, head_last;

  assign rx_full    = (rx_count == RCW'(RX_DEPTH));
  assign rx_empty   = (rx_count == '0);
  assign rx_ready   = !rx_full;
  assign rx_push    = rx_valid && !rx_full;
  assign rx_pop     = rd_rxd && !rx_empty;
  assign rx_end_evt = rx_push && rx_last;
  assign head_last  = !rx_empty && rx_dout[DW];

  pfc_fifo #(.W(DW + 1), .DEPTH(RX_DEPTH), .CW(RCW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .din({rx_last, rx_data}), .dout(rx_dout), .count(rx_count));

  // Event register
  logic [EVT_W-1:0] int_bits;
  pfc_int_status #(.N(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt({ovf_evt, tx_end_evt, rx_end_evt}),
    .clr(rd_int), .bits(int_bits));
  assign irq = |int_bits;

  // Read mux
  logic [STAT_W-1:0] stat;
  assign stat = {status_ovf, head_last, rx_full, !rx_empty, tx_full, tx_empty};

  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      ADDR_RXD:  if (!rx_empty) cpu_rdata = rx_dout[DW-1:0];
      ADDR_STAT: cpu_rdata = DW'(stat);
      ADDR_INT:  cpu_rdata = DW'(int_bits);
      default:   cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pkt_fifo_chan_chk.sv
module pkt_fifo_chan_chk #(
  parameter int DW   = 8,
  parameter int HOLD = 2,
  parameter int HW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_mark,
  input logic          tx_push,
  input logic          tx_mark_push,
  input logic          tx_empty,
  input logic [HW-1:0] held,
  input logic          ovf_evt,
  input logic          status_ovf,
  input logic          rx_push,
  input logic          rx_empty,
  input logic          rx_end_evt,
  input logic          tx_end_evt,
  input logic          rd_int,
  input logic [2:0]    int_bits
);
  a_r2_held_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(held) <= HOLD);

  a_r3_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_mark));

  a_r3_eop_offers: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mark_push |=> tx_valid);

  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status_ovf);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_ovf |=> status_ovf);

  a_r5_tx_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_empty);

  a_r6_rx_stored: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_empty);

  a_r8_rx_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end_evt |=> int_bits[0]);

  a_r8_tx_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_evt |=> int_bits[1]);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_int && !rx_end_evt && !tx_end_evt && !ovf_evt |=> int_bits == 3'b000);
endmodule

bind pkt_fifo_chan pkt_fifo_chan_chk #(.DW(DW), .HOLD(HOLD), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_mark(tx_mark), .tx_push(tx_push),
  .tx_mark_push(tx_mark_push), .tx_empty(tx_empty), .held(held),
  .ovf_evt(ovf_evt), .status_ovf(status_ovf), .rx_push(rx_push),
  .rx_empty(rx_empty), .rx_end_evt(rx_end_evt), .tx_end_evt(tx_end_evt),
  .rd_int(rd_int), .int_bits(int_bits));

// File: tb/pkt_fifo_chan_test.sv
module pkt_fifo_chan_test;
  localparam int DW = 8, TXD = 4, RXD = 4, HOLD = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [2:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, cpu_rdata;
  logic irq, tx_valid, tx_mark, rx_ready;
  logic tx_ready = 0, rx_valid = 0, rx_last = 0;
  logic [DW-1:0] tx_data, rx_data = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW:0] cap [64];
  int cap_n = 0;

  always #5 clk = ~clk;

  pkt_fifo_chan #(.DW(DW), .TX_DEPTH(TXD), .RX_DEPTH(RXD), .HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_mark(tx_mark), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last));

  // Link monitor: record every accepted outgoing beat as {mark, data}.
  always @(posedge clk)
    if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
      cap[cap_n] = {tx_mark, tx_data};
      cap_n++;
    end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int st(bit txe, bit txf, bit rxne, bit rxf, bit hl, bit ov);
    return int'(ov) * 32 + int'(hl) * 16 + int'(rxf) * 8 + int'(rxne) * 4 + int'(txf) * 2 + int'(txe);
  endfunction

  task automatic cpu_write(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic cpu_read(logic [2:0] a, output int v);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    #1 v = int'(cpu_rdata);
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic rx_beat(logic [DW-1:0] d, logic l);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_last = l;
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state (R5, R6, R7)
    chk("R5 reset status", int'({uut.cpu_rdata}) * 0 + 0, 0);
    cpu_read(3'd3, v); chk("R5 reset status", v, st(1, 0, 0, 0, 0, 0));
    chk("R7 reset irq", int'(irq), 0);
    chk("R1 reset tx_valid", int'(tx_valid), 0);
    chk("R6 reset rx_ready", int'(rx_ready), 1);

    // Sweep packet lengths 0..3 with the link stalled (R1, R2, R3, R5)
    for (int k = 0; k <= 3; k++) begin
      cap_n = 0; tx_ready = 0;
      for (int i = 1; i <= k; i++) begin
        cpu_write(3'd0, DW'(16 * k + i));
        chk("R2 released after write", int'(tx_valid), (i > HOLD) ? 1 : 0);
      end
      cpu_read(3'd3, v); chk("R5 tx status", v, st(k == 0, 0, 0, 0, 0, 0));
      cpu_write(3'd1, 0);
      chk("R3 eop offers beat", int'(tx_valid), 1);
      @(negedge clk); tx_ready = 1;
      repeat (8) @(negedge clk);
      tx_ready = 0;
      chk("R3 beat count", cap_n, k + 1);
      for (int i = 0; i < k; i++)
        chk("R1 word order", int'(cap[i]), 16 * k + i + 1);
      chk("R3 end marker", int'(cap[k]), 256);
      cpu_read(3'd4, v); chk("R7 marker event", v, 2);
      cpu_read(3'd4, v); chk("R8 cleared", v, 0);
    end

    // Streaming with the link always ready (R1, R2, R3)
    cap_n = 0; tx_ready = 1;
    for (int i = 0; i < 12; i++) cpu_write(3'd0, DW'(8'h40 + i));
    repeat (2) @(negedge clk);
    chk("R2 stream held back", cap_n, 12 - HOLD);
    cpu_write(3'd1, 0);
    repeat (6) @(negedge clk);
    chk("R3 stream total", cap_n, 13);
    for (int i = 0; i < 12; i++) chk("R1 stream order", int'(cap[i]), 8'h40 + i);
    chk("R3 stream marker", int'(cap[12]), 256);
    cpu_read(3'd4, v); chk("R7 stream event", v, 2);
    tx_ready = 0;

    // Receive sweep over packet lengths 1..4 (R6, R5, R7)
    for (int n = 1; n <= RXD; n++) begin
      for (int j = 0; j < n; j++) begin
        chk("R6 rx_ready with room", int'(rx_ready), 1);
        rx_beat(DW'(16 * n + j), j == n - 1);
      end
      if (n == RXD) begin
        @(negedge clk);
        chk("R6 rx_ready full", int'(rx_ready), 0);
        rx_beat(8'hEE, 1'b0);
      end
      cpu_read(3'd3, v);
      chk("R5 rx status", v, st(1, 0, 1, n == RXD, n == 1, 0));
      chk("R7 irq on rx end", int'(irq), 1);
      cpu_read(3'd4, v); chk("R7 rx event", v, 1);
      for (int j = 0; j < n; j++) begin
        cpu_read(3'd3, v); chk("R6 head tag", (v >> 4) & 1, (j == n - 1) ? 1 : 0);
        cpu_read(3'd2, v); chk("R6 rx data", v, 16 * n + j);
      end
      cpu_read(3'd2, v); chk("R6 empty read", v, 0);
      cpu_read(3'd3, v); chk("R6 empty status", v, st(1, 0, 0, 0, 0, 0));
    end

    // Event in the same cycle as the clearing read (R8)
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h5A; rx_last = 1; cpu_rd = 1; cpu_addr = 3'd4;
    #1 chk("R8 read before event", int'(cpu_rdata), 0);
    @(negedge clk); rx_valid = 0; rx_last = 0; cpu_rd = 0;
    chk("R8 irq kept", int'(irq), 1);
    cpu_read(3'd4, v); chk("R8 event survives clear", v, 1);
    cpu_read(3'd2, v); chk("R6 word after race", v, 8'h5A);

    // Overflow at full transmit FIFO (R4, R2, R3)
    cap_n = 0; tx_ready = 0;
    for (int i = 1; i <= TXD; i++) cpu_write(3'd0, DW'(8'hA0 + i));
    cpu_read(3'd3, v); chk("R5 tx full", v, st(0, 1, 0, 0, 0, 0));
    cpu_write(3'd0, 8'hA5);
    cpu_read(3'd3, v); chk("R4 overflow sticky", v, st(0, 1, 0, 0, 0, 1));
    chk("R7 irq on overflow", int'(irq), 1);
    cpu_write(3'd1, 0);
    @(negedge clk); tx_ready = 1;
    repeat (6) @(negedge clk);
    chk("R2 held at full", cap_n, TXD - HOLD);
    chk("R4 dropped eop", int'(tx_valid), 0);
    cpu_write(3'd1, 0);
    repeat (6) @(negedge clk);
    chk("R4 total after drop", cap_n, TXD + 1);
    for (int i = 0; i < TXD; i++) chk("R4 contents kept", int'(cap[i]), 8'hA1 + i);
    chk("R3 marker after drop", int'(cap[TXD]), 256);
    cpu_read(3'd4, v); chk("R7 overflow and marker", v, 6);
    cpu_read(3'd3, v); chk("R4 overflow stays", v, st(1, 0, 0, 0, 0, 1));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule